// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block maps a bus-master DMA address arriving from the PCI side onto host memory. Four programmable windows, each an enable, a compare base, a size mask and a translated base, decide whether an address falls into translated space. Each window maps its range straight onto a contiguous host region (direct) or points into a page table (scatter-gather). A control register adds two global behaviours: a low-memory hole that blocks matching, and a large fixed range for 64-bit addresses that passes through untranslated.

A request carries one bus address over a valid/ready handshake. For each accepted request the block returns exactly one result, which is one of three kinds. A miss means no window claimed the address. A direct result is the final host address. A table-entry result is the host address of the page-table entry the caller must fetch. Addresses that fit in 32 bits are single-address-cycle requests. Wider addresses are double-address-cycle requests, and only the pass-through range and the last window can serve them. A simple write port loads the registers through fixed write masks, and a combinational read port returns the stored values.

Top module: `dma_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0 and `req_ready` is 1. Every register reads 0, except the last window's base register, which reads 0x2.
- R2: Register address `{sel[1:0], win[1:0]}` uses sel 0 for base, 1 for mask, 2 for translated base and 3 for control. A base write keeps bits 31:20, 1 (scatter-gather) and 0 (enable). A mask write keeps bits 31:20. A translated-base write keeps bits 34:10. A control write keeps bit 5 (hole) and bit 6 (pass-through). The last window's base also keeps bit 39 (DAC enable), and its bit 1 always reads 1.
- R3: A window claims a 32-bit address only when it is enabled and (addr[31:20] AND NOT mask[31:20]) equals base[31:20]. The extended mask is {mask[31:20], 20 ones}.
- R4: For a 32-bit address, windows 0, 1 and 2 are tried in that order, then the last window, but only if its DAC-enable bit is 0. The lowest claiming window decides the result.
- R5: With control bit 5 set, every 32-bit address from 0x80000 to 0xFFFFF misses, whatever the windows hold.
- R6: A direct hit returns kind 1 and the address ({tbase,10'b0} AND NOT ext) OR (addr AND ext), 35 bits wide.
- R7: A scatter-gather hit returns kind 2 and the address ({tbase,10'b0} AND NOT (mask>>10)) OR ((addr AND (mask OR 0xFE000)) >> 10). The low three bits of this result are 0.
- R8: With control bit 6 set, an address in 0x100_0000_0000..0x1FF_FFFF_FFFF returns kind 1 with addr[34:0] as its result.
- R9: An address in 0x800_0000_0000..0xFFF_FFFF_FFFF with the last window's enable and DAC-enable bits both set returns kind 2 and the address ({tbase,10'b0} AND 0x7_FFC0_0000) OR ((addr[31:0] AND 0xFFFF_E000) >> 10). If either bit is clear, the address misses.
- R10: Every other address wider than 32 bits returns kind 0 (miss), including the pass-through range while control bit 6 is clear.
- R11: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. A result appears one cycle after a request is accepted, stays unchanged while `rsp_ready` is low, and each accepted request yields exactly one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write register select {sel, window} |
| reg_wdata | input | 64 | Write data |
| reg_raddr | input | 4 | Read register select {sel, window} |
| reg_rdata | output | 64 | Stored value of the selected register |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | 44 | Bus address to translate |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken this cycle when valid |
| rsp_kind | output | 2 | 0 miss, 1 direct address, 2 table-entry address |
| rsp_addr | output | 35 | Translated host or table-entry address |

## Verification
The bench builds the block with its default of four windows. That count makes the last window distinct from the first three, so the bench can test the DAC-enable gating of 32-bit matches and the wide-address table path through that window. Overlapping windows 0 and 2 show the priority order, and disabling window 0 afterwards shows that window 2 takes over. The hole edges (0x7FFFF, 0x80000, 0xFFFFF) and the first address past a window's mask are checked exactly. Backpressure is tested with a second request waiting behind a stalled result.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;

    localparam int ADDR_W      = 44;
    localparam int SAC_W       = 32;
    localparam int SYS_W       = 35;
    localparam int FLD_W       = 12;
    localparam int FLD_LSB     = SAC_W - FLD_W;
    localparam int TB_W        = 25;
    localparam int TB_LSB      = 10;
    localparam int REG_W       = 64;
    localparam int PTE_SHIFT   = 10;
    localparam int DAC_EN_BIT  = 39;
    localparam int HOLE_BIT    = 5;
    localparam int MONSTER_BIT = 6;
    localparam int MON_TAG     = 40;
    localparam int D3_TAG      = 43;

    localparam logic [SAC_W-1:0] SG_FIXED    = 32'h000F_E000;
    localparam logic [SAC_W-1:0] DAC_PG_MASK = 32'hFFFF_E000;
    localparam logic [SYS_W-1:0] DAC_TB_KEEP = 35'h7_FFC0_0000;
    localparam logic [SAC_W-1:0] HOLE_LO     = 32'h0008_0000;
    localparam logic [SAC_W-1:0] HOLE_HI     = 32'h000F_FFFF;

    typedef enum logic [1:0] {
        KIND_MISS   = 2'd0,
        KIND_DIRECT = 2'd1,
        KIND_PTE    = 2'd2
    } xlate_kind_e;

    typedef enum logic [1:0] {
        RSEL_BASE  = 2'd0,
        RSEL_MASK  = 2'd1,
        RSEL_TBASE = 2'd2,
        RSEL_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             dac;
        logic             sg;
        logic             en;
        logic [FLD_W-1:0] base;
        logic [FLD_W-1:0] mask;
        logic [TB_W-1:0]  tbase;
    } win_cfg_t;

    typedef struct packed {
        logic hole_en;
        logic monster_en;
    } ctl_t;

    typedef struct packed {
        xlate_kind_e      kind;
        logic [SYS_W-1:0] addr;
    } xlate_res_t;

    typedef struct packed {
        logic       hit;
        xlate_res_t r;
    } win_res_t;

    function automatic logic [SYS_W-1:0] tbase_full(input win_cfg_t c);
        return {c.tbase, {TB_LSB{1'b0}}};
    endfunction

    function automatic logic [REG_W-1:0] render_base(input win_cfg_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[DAC_EN_BIT]             = c.dac;
        v[SAC_W-1:FLD_LSB]        = c.base;
        v[1]                      = c.sg;
        v[0]                      = c.en;
        return v;
    endfunction

endpackage

// File: rtl/dma_xlate_regs.sv
module dma_xlate_regs
    import dma_xlate_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W+1:0] waddr,
    input  logic [REG_W-1:0] wdata,
    input  logic [IDX_W+1:0] raddr,
    output logic [REG_W-1:0] rdata,
    output win_cfg_t         cfg_o [NUM_WIN],
    output ctl_t             ctl_o
);

    reg_sel_e         wsel, rsel;
    logic [IDX_W-1:0] widx, ridx;
    logic             unused_wdata;

    assign wsel = reg_sel_e'(waddr[IDX_W+1:IDX_W]);
    assign widx = waddr[IDX_W-1:0];
    assign rsel = reg_sel_e'(raddr[IDX_W+1:IDX_W]);
    assign ridx = raddr[IDX_W-1:0];
    assign unused_wdata = ^{wdata[REG_W-1:DAC_EN_BIT+1], wdata[DAC_EN_BIT-1:SYS_W],
                            wdata[TB_LSB-1:MONSTER_BIT+1], wdata[HOLE_BIT-1:2]};

    // R1 R2: per-window storage with write masks
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam bit IS_LAST = (w == NUM_WIN - 1);
        win_cfg_t q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '{dac: 1'b0, sg: IS_LAST, en: 1'b0,
                       base: '0, mask: '0, tbase: '0};
            end else if (we && widx == IDX_W'(w)) begin
                case (wsel)
                    RSEL_BASE: begin
                        q.en   <= wdata[0];
                        q.sg   <= IS_LAST ? 1'b1 : wdata[1];
                        q.base <= wdata[SAC_W-1:FLD_LSB];
                        q.dac  <= IS_LAST ? wdata[DAC_EN_BIT] : 1'b0;
                    end
                    RSEL_MASK:  q.mask  <= wdata[SAC_W-1:FLD_LSB];
                    RSEL_TBASE: q.tbase <= wdata[SYS_W-1:TB_LSB];
                    default: ;
                endcase
            end
        end

        assign cfg_o[w] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_o <= '0;
        end else if (we && wsel == RSEL_CTRL) begin
            ctl_o.hole_en    <= wdata[HOLE_BIT];
            ctl_o.monster_en <= wdata[MONSTER_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (rsel == RSEL_CTRL) begin
            rdata[HOLE_BIT]    = ctl_o.hole_en;
            rdata[MONSTER_BIT] = ctl_o.monster_en;
        end else begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (ridx == IDX_W'(w)) begin
                    case (rsel)
                        RSEL_BASE:  rdata = render_base(cfg_o[w]);
                        RSEL_MASK:  rdata[SAC_W-1:FLD_LSB] = cfg_o[w].mask;
                        RSEL_TBASE: rdata[SYS_W-1:0] = tbase_full(cfg_o[w]);
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/dma_xlate_win.sv
module dma_xlate_win
    import dma_xlate_pkg::*;
(
    input  win_cfg_t         cfg,
    input  logic [SAC_W-1:0] addr,
    output win_res_t         res
);

    logic [SAC_W-1:0] ext;
    logic [SAC_W-1:0] sg_pick;
    logic [SYS_W-1:0] tb, direct, pte, mask_sh;
    logic             unused_dac;

    assign unused_dac = cfg.dac;

    always_comb begin
        // R3: extended mask covers the low 20 bits
        ext     = {cfg.mask, {FLD_LSB{1'b1}}};
        tb      = tbase_full(cfg);
        // R6
        direct  = (tb & ~SYS_W'(ext)) | SYS_W'(addr & ext);
        // R7
        mask_sh = SYS_W'({cfg.mask, {FLD_LSB{1'b0}}} >> PTE_SHIFT);
        sg_pick = addr & ({cfg.mask, {FLD_LSB{1'b0}}} | SG_FIXED);
        pte     = (tb & ~mask_sh) | SYS_W'(sg_pick >> PTE_SHIFT);

        res.hit = cfg.en && ((addr[SAC_W-1:FLD_LSB] & ~cfg.mask) == cfg.base);
        if (!res.hit) begin
            res.r.kind = KIND_MISS;
            res.r.addr = '0;
        end else if (cfg.sg) begin
            res.r.kind = KIND_PTE;
            res.r.addr = pte;
        end else begin
            res.r.kind = KIND_DIRECT;
            res.r.addr = direct;
        end
    end

endmodule

// File: rtl/dma_xlate_pick.sv
module dma_xlate_pick
    import dma_xlate_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  win_res_t          wres [NUM_WIN],
    input  logic              last_dac,
    input  logic              last_en,
    input  logic [SYS_W-1:0]  last_tb,
    input  ctl_t              ctl,
    output xlate_res_t        res
);

    logic is_sac, in_hole, took_last;

    always_comb begin
        res       = '{kind: KIND_MISS, addr: '0};
        took_last = 1'b0;
        is_sac    = (addr[ADDR_W-1:SAC_W] == '0);
        // R5
        in_hole   = ctl.hole_en && addr[SAC_W-1:0] >= HOLE_LO
                                && addr[SAC_W-1:0] <= HOLE_HI;
        if (is_sac) begin
            if (!in_hole) begin
                // R4: descending walk, lowest claiming window is written last
                for (int w = NUM_WIN - 1; w >= 0; w--) begin
                    if (wres[w].hit && (w != NUM_WIN - 1 || !last_dac)) begin
                        res       = wres[w].r;
                        took_last = (w == NUM_WIN - 1);
                    end
                end
            end
        end else begin
            // R8
            if ((addr >> MON_TAG) == ADDR_W'(1) && ctl.monster_en) begin
                res = '{kind: KIND_DIRECT, addr: addr[SYS_W-1:0]};
            end
            // R9
            if ((addr >> D3_TAG) == ADDR_W'(1) && last_dac && last_en) begin
                res = '{kind: KIND_PTE,
                        addr: (last_tb & DAC_TB_KEEP)
                              | SYS_W'((addr[SAC_W-1:0] & DAC_PG_MASK) >> PTE_SHIFT)};
            end
        end
    end

    // R4
    sac_last_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (is_sac && took_last) |-> !last_dac);

    // R5
    hole_block_chk: assert property (@(posedge clk) disable iff (rst)
        (is_sac && in_hole) |-> res.kind == KIND_MISS);

endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
    import dma_xlate_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [IDX_W+1:0]  reg_waddr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [IDX_W+1:0]  reg_raddr,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_kind,
    output logic [SYS_W-1:0]  rsp_addr
);

    win_cfg_t   cfg [NUM_WIN];
    win_res_t   wres [NUM_WIN];
    ctl_t       ctl;
    xlate_res_t next_res, res_q;
    logic       accept;

    dma_xlate_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .raddr (reg_raddr),
        .rdata (reg_rdata),
        .cfg_o (cfg),
        .ctl_o (ctl)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        dma_xlate_win u_win (
            .cfg  (cfg[w]),
            .addr (req_addr[SAC_W-1:0]),
            .res  (wres[w])
        );
    end

    dma_xlate_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .clk      (clk),
        .rst      (rst),
        .addr     (req_addr),
        .wres     (wres),
        .last_dac (cfg[NUM_WIN-1].dac),
        .last_en  (cfg[NUM_WIN-1].en),
        .last_tb  (tbase_full(cfg[NUM_WIN-1])),
        .ctl      (ctl),
        .res      (next_res)
    );

    // R11: single output stage
    assign req_ready = !rsp_valid || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            res_q     <= '{kind: KIND_MISS, addr: '0};
        end else if (accept) begin
            rsp_valid <= 1'b1;
            res_q     <= next_res;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    assign rsp_kind = res_q.kind;
    assign rsp_addr = res_q.addr;

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !rsp_valid);

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_addr));

    // R7
    pte_align_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == KIND_PTE) |-> rsp_addr[2:0] == 3'b000);

    // R8
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (req_addr >> MON_TAG) == ADDR_W'(1) && ctl.monster_en)
        |=> rsp_valid && rsp_kind == KIND_DIRECT && rsp_addr == $past(req_addr[SYS_W-1:0]));

endmodule

// File: tb/sim_dma_xlate.sv
module sim_dma_xlate;

    localparam logic [1:0] KM = 2'd0;
    localparam logic [1:0] KD = 2'd1;
    localparam logic [1:0] KP = 2'd2;
    localparam int NV = 12;

    // {addr[43:0], kind[1:0], expected[34:0]}
    localparam logic [80:0] VECS [NV] = '{
        {44'h000_4123_4567, KD, 35'h2_0123_4567},
        {44'h000_4FFF_FFFF, KD, 35'h2_0FFF_FFFF},
        {44'h000_4000_1234, KD, 35'h2_0000_1234},
        {44'h000_800A_5678, KP, 35'h0_1234_0290},
        {44'h000_800F_FFFF, KP, 35'h0_1234_03F8},
        {44'h000_8010_0000, KM, 35'h0},
        {44'h000_D02F_E008, KP, 35'h0_8000_0BF8},
        {44'h000_D040_0000, KM, 35'h0},
        {44'h000_1000_0000, KM, 35'h0},
        {44'h100_0000_1000, KM, 35'h0},
        {44'h001_0000_0000, KM, 35'h0},
        {44'h4FF_FFFF_FFFF, KM, 35'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [63:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [63:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [43:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [1:0]  rsp_kind;
    logic [34:0] rsp_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dma_xlate u0 (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_kind(rsp_kind), .rsp_addr(rsp_addr)
    );

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [63:0] e, input string tag);
        @(negedge clk);
        reg_raddr = a;
        #1;
        chk(reg_rdata == e, $sformatf("%s reg %0d: actual %h expected %h", tag, a, reg_rdata, e));
    endtask

    task automatic xact(input logic [43:0] a, input logic [1:0] k,
                        input logic [34:0] e, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_kind == k && (k == KM || rsp_addr == e),
            $sformatf("%s addr %h: actual v=%0d k=%0d a=%h expected k=%0d a=%h",
                      tag, a, rsp_valid, rsp_kind, rsp_addr, k, e));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #1;
        chk(!rsp_valid && req_ready,
            $sformatf("R1 handshake: actual v=%0d r=%0d expected v=0 r=1", rsp_valid, req_ready));
        for (int i = 0; i < 13; i++) begin
            rd(4'(i), (i == 3) ? 64'h2 : 64'h0, "R1");
        end

        // R2: write masks
        wr(4'd0, '1);  rd(4'd0, 64'h0000_0000_FFF0_0003, "R2 base");
        wr(4'd4, '1);  rd(4'd4, 64'h0000_0000_FFF0_0000, "R2 mask");
        wr(4'd8, '1);  rd(4'd8, 64'h0000_0007_FFFF_FC00, "R2 tbase");
        wr(4'd3, '1);  rd(4'd3, 64'h0000_0080_FFF0_0003, "R2 last base");
        wr(4'd3, '0);  rd(4'd3, 64'h2, "R2 last sg forced");
        wr(4'd12, '1); rd(4'd12, 64'h60, "R2 ctrl");

        // configuration
        wr(4'd12, 64'h0);
        wr(4'd0, 64'h4000_0001); wr(4'd4, 64'h0FF0_0000); wr(4'd8, 64'h2_0000_0000);
        wr(4'd1, 64'h8000_0003); wr(4'd5, 64'h0);         wr(4'd9, 64'h0_1234_0000);
        wr(4'd2, 64'h4000_0001); wr(4'd6, 64'h0);         wr(4'd10, 64'h3_0000_0000);
        wr(4'd3, 64'hD000_0001); wr(4'd7, 64'h0030_0000); wr(4'd11, 64'h0_8000_0000);

        // R3 R4 R6 R7 R10: vector table
        for (int v = 0; v < NV; v++) begin
            xact(VECS[v][80:37], VECS[v][36:35], VECS[v][34:0],
                 $sformatf("R3 R4 R6 R7 R10 vector %0d", v));
        end

        // R11: backpressure with a waiting request
        @(negedge clk);
        rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 44'h000_4123_4567;
        @(negedge clk);
        req_addr = 44'h000_800A_5678;
        chk(rsp_valid && !req_ready && rsp_addr == 35'h2_0123_4567,
            $sformatf("R11 stall1: actual v=%0d r=%0d a=%h expected 1 0 201234567",
                      rsp_valid, req_ready, rsp_addr));
        @(negedge clk);
        chk(rsp_valid && rsp_kind == KD && rsp_addr == 35'h2_0123_4567,
            $sformatf("R11 stall2: actual v=%0d k=%0d a=%h expected 1 1 201234567",
                      rsp_valid, rsp_kind, rsp_addr));
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_kind == KP && rsp_addr == 35'h0_1234_0290,
            $sformatf("R11 second: actual v=%0d k=%0d a=%h expected 1 2 12340290",
                      rsp_valid, rsp_kind, rsp_addr));
        @(negedge clk);
        chk(!rsp_valid && req_ready,
            $sformatf("R11 drain: actual v=%0d r=%0d expected 0 1", rsp_valid, req_ready));

        // R9 and R4 DAC gating
        wr(4'd3, 64'h80_D000_0001);
        xact(44'h8AB_1234_5678, KP, 35'h0_8004_8D10, "R9 wide table");
        xact(44'h000_D02F_E008, KM, 35'h0, "R4 last window gated");
        wr(4'd3, 64'h80_D000_0000);
        xact(44'h8AB_1234_5678, KM, 35'h0, "R9 disabled");

        // R8 and R10
        wr(4'd12, 64'h40);
        xact(44'h1AB_CDEF_0123, KD, 35'h3_CDEF_0123, "R8 pass-through");
        xact(44'h200_0000_0000, KM, 35'h0, "R10 outside ranges");

        // R3: disabled window 0 lets window 2 claim
        wr(4'd0, 64'h0);
        xact(44'h000_4000_1234, KD, 35'h3_0000_1234, "R3 disabled window");

        // R5: hole
        wr(4'd1, 64'h1); wr(4'd9, 64'h1_0000_0000); wr(4'd12, 64'h0);
        xact(44'h000_0009_0000, KD, 35'h1_0009_0000, "R5 hole off");
        wr(4'd12, 64'h20);
        xact(44'h000_0009_0000, KM, 35'h0, "R5 hole on");
        xact(44'h000_0008_0000, KM, 35'h0, "R5 hole low edge");
        xact(44'h000_000F_FFFF, KM, 35'h0, "R5 hole high edge");
        xact(44'h000_0007_FFFF, KD, 35'h1_0007_FFFF, "R5 below hole");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule